// File: doc/BRIEF.md
# Shared Reference Divider with Test Routing

This block divides a single reference clock through one free-running binary counter and taps two comparison-frequency enables from it, one per synthesiser loop. Each loop picks its own power-of-two ratio with a 3-bit code. Loop 1 covers ratios 2 to 256 and loop 2 covers ratios 4 to 512. Both taps read the same counter, so the two enables stay phase-aligned whenever their ratios are equal.

A small test-mode decoder sits beside the divider. In normal operation the two switching-port outputs follow their latched levels and the charge-pump override lines stay low. With the test-enable bit set, the decoder can do one of four things:
- force both pumps to sink;
- force both pumps to source;
- put the comparison enables on the ports and disable the pumps;
- put divide-by-2 copies of the two loop divider outputs on the ports.

All outputs are registered. Reset is synchronous and active high.

Top module: `shared_refdiv`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge, and the counter restarts from 0.
- R2: `cmp1_en` is a one-cycle pulse whose period is 2^(`code1`+1) cycles. After `rst` is released, it is first high after clock edge number 2^(`code1`+1).
- R3: `cmp2_en` is a one-cycle pulse whose period is 2^(`code2`+2) cycles. After `rst` is released, it is first high after clock edge number 2^(`code2`+2).
- R4: Both enables come from one shared counter. When `code1` equals `code2`+1, `cmp1_en` and `cmp2_en` are high in exactly the same cycles.
- R5: The test bits are encoded as `test_bits[0]`=test enable, `test_bits[1]`=mode bit A and `test_bits[2]`=mode bit B. When `test_bits[0]` is 0:
  - one cycle later, `port_out` equals `port_bits`, where bit 1 is port P1 and bit 0 is port P0;
  - all three pump controls are 0;
  - bits 2:1 have no effect.
- R6: With `test_bits`=3'b001, `pump_sink` is 1 one cycle later, and `port_out` still follows `port_bits`.
- R7: With `test_bits`=3'b011, `pump_source` is 1 one cycle later, and `port_out` still follows `port_bits`.
- R8: With `test_bits`=3'b101, `pump_off` is 1, `port_out[1]` carries the loop-1 comparison pulse and `port_out[0]` carries the loop-2 comparison pulse. Each port bit is high in the same cycles as `cmp1_en` and `cmp2_en` respectively.
- R9: With `test_bits`=3'b111:
  - `port_out[1]` shows a toggle flop that flips on each cycle where `div1_pulse` is high;
  - `port_out[0]` shows a toggle flop that flips on each cycle where `div2_pulse` is high;
  - both toggle flops reset to 0, and each port lags its flop by one cycle.
- R10: At most one of `pump_sink`, `pump_source` and `pump_off` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| code1 | input | 3 | Loop-1 ratio code |
| code2 | input | 3 | Loop-2 ratio code |
| test_bits | input | 3 | Test enable (bit 0) and mode bits (bits 2:1) |
| port_bits | input | 2 | Latched port levels, bit 1 = P1, bit 0 = P0 |
| div1_pulse | input | 1 | Loop-1 programmable divider output pulse |
| div2_pulse | input | 1 | Loop-2 programmable divider output pulse |
| cmp1_en | output | 1 | Loop-1 comparison enable |
| cmp2_en | output | 1 | Loop-2 comparison enable |
| port_out | output | 2 | Switching-port drive, bit 1 = P1, bit 0 = P0 |
| pump_sink | output | 1 | Force both pumps to sink |
| pump_source | output | 1 | Force both pumps to source |
| pump_off | output | 1 | Disable both pumps |

## Verification
The bench builds the block with its default parameters: a 3-bit code, a loop-1 shift of 1 and a loop-2 shift of 2. This gives a 9-bit counter, so the largest ratio of 512 and the counter's wrap fall within about a thousand cycles. The bench tests the smallest, a middle and the largest code for each loop. It also tests the ratio pairing at which the two taps must coincide. Each test mode is entered with port levels that differ from the value the mode should produce, so that a wrong selection shows up at the ports.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int TEST_W = 3;
  localparam int PORT_W = 2;

  typedef enum logic [2:0] {
    MODE_NORMAL,
    MODE_SINK,
    MODE_SOURCE,
    MODE_CMP,
    MODE_HALF
  } srd_mode_e;

  function automatic srd_mode_e decode_mode(input logic [TEST_W-1:0] t);
    srd_mode_e m;
    if (!t[0]) m = MODE_NORMAL;
    else begin
      case (t[2:1])
        2'b00:   m = MODE_SINK;
        2'b01:   m = MODE_SOURCE;
        2'b10:   m = MODE_CMP;
        default: m = MODE_HALF;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/srd_chain.sv
module srd_chain #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srd_tap.sv
module srd_tap #(
  parameter int CNT_W  = 9,
  parameter int CODE_W = 3,
  parameter int SHIFT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CODE_W-1:0] code,
  output logic              hit_next,
  output logic              en
);
  logic [CNT_W-1:0] mask;

  // low (code+SHIFT) bits of the counter take part in the compare
  always_comb begin
    for (int i = 0; i < CNT_W; i++)
      mask[i] = (i < (int'(code) + SHIFT));
    hit_next = &(cnt | ~mask);
  end

  always_ff @(posedge clk) begin
    if (rst) en <= 1'b0;
    else     en <= hit_next;
  end
endmodule

// File: rtl/srd_halver.sv
module srd_halver (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (pulse) q <= ~q;
  end
endmodule

// File: rtl/srd_route.sv
module srd_route
  import srd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [TEST_W-1:0] test_bits,
  input  logic [PORT_W-1:0] port_bits,
  input  logic [1:0]        hit_next,
  input  logic [1:0]        half,
  output logic [PORT_W-1:0] port_out,
  output logic              pump_sink,
  output logic              pump_source,
  output logic              pump_off
);
  srd_mode_e        mode;
  logic [PORT_W-1:0] port_d;

  always_comb begin
    mode = decode_mode(test_bits);
    case (mode)
      MODE_CMP:  port_d = {hit_next[0], hit_next[1]};
      MODE_HALF: port_d = {half[0], half[1]};
      default:   port_d = port_bits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_out    <= '0;
      pump_sink   <= 1'b0;
      pump_source <= 1'b0;
      pump_off    <= 1'b0;
    end else begin
      port_out    <= port_d;
      pump_sink   <= (mode == MODE_SINK);
      pump_source <= (mode == MODE_SOURCE);
      pump_off    <= (mode == MODE_CMP);
    end
  end
endmodule

// File: rtl/shared_refdiv.sv
module shared_refdiv
  import srd_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int LOOP1_SHIFT = 1,
  parameter int LOOP2_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code1,
  input  logic [CODE_W-1:0] code2,
  input  logic [TEST_W-1:0] test_bits,
  input  logic [PORT_W-1:0] port_bits,
  input  logic              div1_pulse,
  input  logic              div2_pulse,
  output logic              cmp1_en,
  output logic              cmp2_en,
  output logic [PORT_W-1:0] port_out,
  output logic              pump_sink,
  output logic              pump_source,
  output logic              pump_off
);
  localparam int MAX_SHIFT = (LOOP1_SHIFT > LOOP2_SHIFT) ? LOOP1_SHIFT : LOOP2_SHIFT;
  localparam int CNT_W     = (1 << CODE_W) - 1 + MAX_SHIFT;

  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] codes [2];
  logic [1:0]        pulses;
  logic [1:0]        hit_next;
  logic [1:0]        en;
  logic [1:0]        half;

  assign codes[0] = code1;
  assign codes[1] = code2;
  assign pulses   = {div2_pulse, div1_pulse};
  assign cmp1_en  = en[0];
  assign cmp2_en  = en[1];

  srd_chain #(.CNT_W(CNT_W)) u_chain (.clk(clk), .rst(rst), .cnt(cnt));

  for (genvar g = 0; g < 2; g++) begin : g_loop
    localparam int SH = (g == 0) ? LOOP1_SHIFT : LOOP2_SHIFT;
    srd_tap #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SHIFT(SH)) u_tap (
      .clk(clk), .rst(rst), .cnt(cnt), .code(codes[g]),
      .hit_next(hit_next[g]), .en(en[g])
    );
    srd_halver u_half (.clk(clk), .rst(rst), .pulse(pulses[g]), .q(half[g]));
  end

  srd_route u_route (
    .clk(clk), .rst(rst), .test_bits(test_bits), .port_bits(port_bits),
    .hit_next(hit_next), .half(half), .port_out(port_out),
    .pump_sink(pump_sink), .pump_source(pump_source), .pump_off(pump_off)
  );
endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code1,
  input logic [CODE_W-1:0] code2,
  input logic [2:0]        test_bits,
  input logic [1:0]        port_bits,
  input logic [1:0]        port_out,
  input logic              cmp1_en,
  input logic              cmp2_en,
  input logic              pump_sink,
  input logic              pump_source,
  input logic              pump_off
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (port_out == 2'b00 && !cmp1_en && !cmp2_en && !pump_sink && !pump_source && !pump_off));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmp1_en |=> !cmp1_en);

  a_r4_taps_aligned: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, code1} == {1'b0, code2} + 1'b1) |=> (cmp1_en == cmp2_en));

  a_r5_normal_ports: assert property (@(posedge clk) disable iff (rst)
    !test_bits[0] |=> (port_out == $past(port_bits) && !pump_sink && !pump_source && !pump_off));

  a_r6_sink: assert property (@(posedge clk) disable iff (rst)
    (test_bits == 3'b001) |=> (pump_sink && port_out == $past(port_bits)));

  a_r7_source: assert property (@(posedge clk) disable iff (rst)
    (test_bits == 3'b011) |=> (pump_source && port_out == $past(port_bits)));

  a_r8_cmp_route: assert property (@(posedge clk) disable iff (rst)
    (test_bits == 3'b101) |=> (pump_off && port_out[1] == cmp1_en && port_out[0] == cmp2_en));

  a_r10_one_pump: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pump_sink, pump_source, pump_off}));
endmodule

bind shared_refdiv srd_checker #(.CODE_W(CODE_W)) u_srd_checker (
  .clk(clk), .rst(rst), .code1(code1), .code2(code2), .test_bits(test_bits),
  .port_bits(port_bits), .port_out(port_out), .cmp1_en(cmp1_en), .cmp2_en(cmp2_en),
  .pump_sink(pump_sink), .pump_source(pump_source), .pump_off(pump_off)
);

// File: tb/test_shared_refdiv.sv
module test_shared_refdiv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] code1 = '0, code2 = '0, test_bits = '0;
  logic [1:0] port_bits = '0;
  logic       div1_pulse = 1'b0, div2_pulse = 1'b0;
  logic       cmp1_en, cmp2_en, pump_sink, pump_source, pump_off;
  logic [1:0] port_out;
  int         total = 0, failed = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  shared_refdiv i_shared_refdiv (
    .clk(clk), .rst(rst), .code1(code1), .code2(code2), .test_bits(test_bits),
    .port_bits(port_bits), .div1_pulse(div1_pulse), .div2_pulse(div2_pulse),
    .cmp1_en(cmp1_en), .cmp2_en(cmp2_en), .port_out(port_out),
    .pump_sink(pump_sink), .pump_source(pump_source), .pump_off(pump_off)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    test_bits = 3'b101; port_bits = 2'b11; div1_pulse = 1'b1; div2_pulse = 1'b1;
    @(negedge clk); rst = 1'b1;
    wait_cycles(2);
    chk(port_out, 0, "R1 port_out");
    chk({cmp1_en, cmp2_en}, 0, "R1 cmp enables");
    chk({pump_sink, pump_source, pump_off}, 0, "R1 pumps");
    div1_pulse = 1'b0; div2_pulse = 1'b0; test_bits = 3'b000; port_bits = 2'b00;
    rst = 1'b0;
  endtask

  // R2 R3: ratio taps, counted from reset release; R4 when pairing coincides
  task automatic t_ratio(input int c1, input int c2, input int cycles);
    int r1, r2, bad1, bad2, bad4;
    r1 = 1 << (c1 + 1); r2 = 1 << (c2 + 2);
    bad1 = 0; bad2 = 0; bad4 = 0;
    code1 = c1[2:0]; code2 = c2[2:0]; test_bits = 3'b000;
    do_reset();
    for (int n = 1; n <= cycles; n++) begin
      @(posedge clk); @(negedge clk);
      if (cmp1_en != ((n % r1) == 0)) begin
        bad1++;
        if (bad1 == 1) chk(cmp1_en, ((n % r1) == 0), "R2 cmp1_en period");
      end
      if (cmp2_en != ((n % r2) == 0)) begin
        bad2++;
        if (bad2 == 1) chk(cmp2_en, ((n % r2) == 0), "R3 cmp2_en period");
      end
      if (r1 == r2 && cmp1_en != cmp2_en) begin
        bad4++;
        if (bad4 == 1) chk(cmp1_en, cmp2_en, "R4 shared alignment");
      end
    end
    if (bad1 == 0) chk(1, 1, "R2 cmp1_en period");
    if (bad2 == 0) chk(1, 1, "R3 cmp2_en period");
    if (r1 == r2 && bad4 == 0) chk(1, 1, "R4 shared alignment");
  endtask

  // R5 R6 R7: port follow and pump override
  task automatic t_mode(input logic [2:0] tb_bits, input logic [1:0] pb,
                        input int exp_pumps, input string req);
    @(negedge clk); test_bits = tb_bits; port_bits = pb;
    wait_cycles(2);
    chk(port_out, pb, req);
    chk({pump_sink, pump_source, pump_off}, exp_pumps, req);
  endtask

  // R8: comparison pulses routed to ports
  task automatic t_cmp_route();
    int bad;
    bad = 0;
    code1 = 3'd1; code2 = 3'd1; test_bits = 3'b101; port_bits = 2'b11;
    do_reset();
    for (int n = 1; n <= 40; n++) begin
      @(posedge clk); @(negedge clk);
      if (port_out != {((n % 4) == 0), ((n % 8) == 0)} || !pump_off) begin
        bad++;
        if (bad == 1) chk({port_out, pump_off}, {((n % 4) == 0), ((n % 8) == 0), 1'b1}, "R8 cmp route");
      end
    end
    if (bad == 0) chk(1, 1, "R8 cmp route");
  endtask

  // R9: halved divider outputs
  task automatic t_half();
    test_bits = 3'b111; port_bits = 2'b11;
    do_reset();
    wait_cycles(2);
    chk(port_out, 0, "R9 halves start at 0");
    div1_pulse = 1'b1; @(negedge clk); div1_pulse = 1'b0;
    wait_cycles(2);
    chk(port_out, 2, "R9 P1 after one div1 pulse");
    div2_pulse = 1'b1; wait_cycles(3); div2_pulse = 1'b0;
    wait_cycles(2);
    chk(port_out, 3, "R9 P0 after three div2 pulses");
    div1_pulse = 1'b1; @(negedge clk); div1_pulse = 1'b0;
    wait_cycles(2);
    chk(port_out, 1, "R9 P1 back to 0");
    chk(pump_off, 0, "R10 no pump override in halve mode");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratio(0, 0, 40);
    t_ratio(3, 2, 200);
    t_ratio(7, 7, 1100);
    t_ratio(2, 5, 300);
    code1 = 3'd0; code2 = 3'd0;
    do_reset();
    t_mode(3'b000, 2'b10, 0, "R5 normal ports");
    t_mode(3'b110, 2'b01, 0, "R5 mode bits ignored");
    t_mode(3'b001, 2'b10, 4, "R6 sink override");
    t_mode(3'b011, 2'b01, 2, "R7 source override");
    t_mode(3'b010, 2'b11, 0, "R5 mode bits ignored with T0 low");
    t_cmp_route();
    t_half();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule